// File: doc/BRIEF.md
# Gated Capture Timer Channel

One channel of a general-purpose up-counting timer. A selectable source feeds a programmable prescaler. The source is the system clock, a fixed divide-by-16 of it, or rising edges of an external input. The prescaler output advances a counter. The counter is compared against a reference value. On a match it either keeps counting or clears, depending on a mode bit. A separate capture register stores the counter value when a chosen edge is seen on the same external input.

An external gate input can hold the counter. In normal gating, a falling gate edge opens the gate and a rising edge closes it. In restart gating, the falling edge also clears the counter, which suits pulse-interval measurement.

A carry output pulses while the counter steps past its all-ones value. A channel whose source select is set to cascade counts on its carry input instead of its prescaler. Several channels can be chained this way into one wider counter.

Top module: `gptimer_channel`

## Requirements
- R1: After reset: count, capture, match_pulse, match_flag and cap_flag are 0, the reference is all ones, the prescale value is 0 and the gate is closed.
- R2: cfg_src selects the count source. 00 is every system clock, 01 is one clock in every 16 (a free-running divider started at reset), 10 is each rising edge of the synchronized tin, and 11 is cascade, where each cycle with carry_in high is one count and the prescaler is bypassed.
- R3: With prescale value P, the counter advances once per P+1 source ticks. A pre_wr loads P and restarts the division from zero.
- R4: An increment taken while count equals the reference is a match. match_pulse is high for exactly the following cycle and match_flag sets. match_clr clears the flag; a new match wins over the clear.
- R5: On a match with cfg_ref_reset=1 the counter goes to 0. With cfg_ref_reset=0 it goes to reference+1.
- R6: cfg_cap_edge selects the capture edge on the synchronized tin: 00 none, 01 rising, 10 falling, 11 both. On that edge, capture takes the current count and cap_flag sets. cap_clr clears the flag; a new capture wins over the clear.
- R7: With cfg_gate_en=1, a falling edge of the synchronized gate_in opens counting and a rising edge closes it. While closed, the counter and prescaler hold.
- R8: With cfg_gate_en=1 and cfg_gate_restart=1, a falling gate edge also clears the counter to 0. This clear wins over an increment in the same cycle.
- R9: With cfg_gate_en=0, counting depends only on cfg_en and the source.
- R10: carry_out is high, combinationally, in a cycle where an increment is taken at count 0xFFFF, and the counter then reads 0.
- R11: cnt_wr loads cnt_wdata into the counter. It wins over restart clear and increment.
- R12: tin and gate_in pass through two flops before edge detection. A capture from a tin edge set up before posedge k is visible after posedge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_src | input | 2 | Count source select |
| cfg_ref_reset | input | 1 | 1: clear on reference match, 0: free run |
| cfg_gate_en | input | 1 | Enable gating by gate_in |
| cfg_gate_restart | input | 1 | Clear the counter on gate falling edge |
| cfg_cap_edge | input | 2 | Capture edge select |
| pre_wr | input | 1 | Prescale value write strobe |
| pre_wdata | input | PRE_W | Prescale value |
| ref_wr | input | 1 | Reference write strobe |
| ref_wdata | input | CNT_W | Reference value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| match_clr | input | 1 | Clear match_flag |
| cap_clr | input | 1 | Clear cap_flag |
| tin | input | 1 | External source and capture input, asynchronous |
| gate_in | input | 1 | External gate input, asynchronous |
| carry_in | input | 1 | Carry from the lower channel in cascade |
| count | output | CNT_W | Counter value |
| capture | output | CNT_W | Captured counter value |
| match_pulse | output | 1 | One-cycle reference match event |
| match_flag | output | 1 | Sticky match status |
| cap_flag | output | 1 | Sticky capture status |
| carry_out | output | 1 | Counter wrap from all ones |

## Verification
Register writes, increments, matches and captures show on the outputs one edge after the cycle that causes them. carry_out responds in the same cycle. A tin or gate_in change shows only after two synchronizer edges plus the acting edge, so its effect appears three edges later. Inputs are driven just after the falling edge. The bench compares every output at the next falling edge against a cycle model, which keeps its own two-flop history of the pins. The directed checks count exact edges before they sample: 20 edges for a divide-by-4 run, 4 edges for a reference of 3, and 2 then 3 edges for the capture latency.

// File: rtl/gptimer_channel.sv
module gptimer_channel #(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_src,
  input  logic             cfg_ref_reset,
  input  logic             cfg_gate_en,
  input  logic             cfg_gate_restart,
  input  logic [1:0]       cfg_cap_edge,
  input  logic             pre_wr,
  input  logic [PRE_W-1:0] pre_wdata,
  input  logic             ref_wr,
  input  logic [CNT_W-1:0] ref_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             match_clr,
  input  logic             cap_clr,
  input  logic             tin,
  input  logic             gate_in,
  input  logic             carry_in,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             match_pulse,
  output logic             match_flag,
  output logic             cap_flag,
  output logic             carry_out
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0] tin_sh, gate_sh;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q, pre_val;
  logic [CNT_W-1:0] ref_q;
  logic gate_open, src_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tin_sh  <= '0;
      gate_sh <= '0;
    end else begin
      tin_sh  <= {tin_sh[1:0], tin};
      gate_sh <= {gate_sh[1:0], gate_in};
    end

  wire tin_rise  =  tin_sh[1] & ~tin_sh[2];
  wire tin_fall  = ~tin_sh[1] &  tin_sh[2];
  wire gate_rise =  gate_sh[1] & ~gate_sh[2];
  wire gate_fall = ~gate_sh[1] &  gate_sh[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                       div_q <= div_q + 1'b1;

  always_comb
    case (cfg_src)
      2'b00:   src_tick = 1'b1;
      2'b01:   src_tick = (div_q == DIV_LAST);
      2'b10:   src_tick = tin_rise;
      default: src_tick = 1'b0;
    endcase

  wire run         = cfg_en & (~cfg_gate_en | gate_open);
  wire pre_hit     = src_tick & (pre_q == pre_val);
  wire cnt_tick    = (cfg_src == 2'b11) ? carry_in : pre_hit;
  wire inc         = run & cnt_tick;
  wire match_hit   = inc & (count == ref_q);
  wire restart_clr = cfg_gate_en & cfg_gate_restart & gate_fall;
  wire cap_hit     = (cfg_cap_edge[0] & tin_rise) | (cfg_cap_edge[1] & tin_fall);

  assign carry_out = inc & (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q   <= '0;
      pre_val <= '0;
    end else begin
      if (pre_wr) pre_val <= pre_wdata;
      if (pre_wr)
        pre_q <= '0;
      else if (run && src_tick && cfg_src != 2'b11)
        pre_q <= pre_hit ? '0 : pre_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         gate_open <= 1'b0;
    else if (gate_fall) gate_open <= 1'b1;
    else if (gate_rise) gate_open <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_q       <= CNT_MAX;
      count       <= '0;
      match_pulse <= 1'b0;
      match_flag  <= 1'b0;
      capture     <= '0;
      cap_flag    <= 1'b0;
    end else begin
      if (ref_wr) ref_q <= ref_wdata;
      if (cnt_wr)           count <= cnt_wdata;
      else if (restart_clr) count <= '0;
      else if (inc)         count <= (match_hit && cfg_ref_reset) ? '0 : count + 1'b1;
      match_pulse <= match_hit;
      match_flag  <= match_hit | (match_flag & ~match_clr);
      if (cap_hit) capture <= count;
      cap_flag    <= cap_hit | (cap_flag & ~cap_clr);
    end

  assert_match_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> match_flag);
  assert_ref_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit && cfg_ref_reset && !cnt_wr && !restart_clr) |=> count == '0);
  assert_capture_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(capture) |-> cap_flag);
  assert_gate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate_en && !gate_open && !gate_fall && !cnt_wr) |=> $stable(count));
  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_clr && !cnt_wr) |=> count == '0);
  assert_carry_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_out && !cnt_wr && !restart_clr) |=> count == '0);
  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(cnt_wdata));
endmodule

// File: tb/gptimer_channel_tb_top.sv
module gptimer_channel_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 0, cfg_ref_reset = 0, cfg_gate_en = 0, cfg_gate_restart = 0;
  logic [1:0] cfg_src = 0, cfg_cap_edge = 0;
  logic pre_wr = 0, ref_wr = 0, cnt_wr = 0, match_clr = 0, cap_clr = 0;
  logic [7:0] pre_wdata = 0;
  logic [15:0] ref_wdata = 0, cnt_wdata = 0;
  logic tin = 0, gate_in = 0, carry_in = 0;
  logic [15:0] count, capture;
  logic match_pulse, match_flag, cap_flag, carry_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gptimer_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src(cfg_src),
    .cfg_ref_reset(cfg_ref_reset), .cfg_gate_en(cfg_gate_en),
    .cfg_gate_restart(cfg_gate_restart), .cfg_cap_edge(cfg_cap_edge),
    .pre_wr(pre_wr), .pre_wdata(pre_wdata), .ref_wr(ref_wr), .ref_wdata(ref_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .match_clr(match_clr), .cap_clr(cap_clr),
    .tin(tin), .gate_in(gate_in), .carry_in(carry_in), .count(count),
    .capture(capture), .match_pulse(match_pulse), .match_flag(match_flag),
    .cap_flag(cap_flag), .carry_out(carry_out));

  // cycle model built from the requirements
  logic [2:0] mt, mg;
  logic [3:0] mdiv;
  logic [7:0] mpq, mpv;
  logic [15:0] mref, mcnt, mcap;
  logic mopen, mcapf, mmf, mmp;

  function automatic logic m_tick();
    logic st;
    case (cfg_src)
      2'd0: st = 1'b1;
      2'd1: st = (mdiv == 4'd15);
      2'd2: st = mt[1] & ~mt[2];
      default: st = 1'b0;
    endcase
    return st;
  endfunction

  function automatic logic m_inc();
    logic go;
    go = cfg_en && (!cfg_gate_en || mopen);
    if (cfg_src == 2'd3) return go && carry_in;
    return go && m_tick() && (mpq == mpv);
  endfunction

  always @(posedge clk) begin : model
    logic inc, hit, tr, tf, gf, gr, st, go;
    if (!rst_n) begin
      mt = 0; mg = 0; mdiv = 0; mpq = 0; mpv = 0; mref = 16'hFFFF; mcnt = 0;
      mcap = 0; mopen = 0; mcapf = 0; mmf = 0; mmp = 0;
    end else begin
      inc = m_inc(); st = m_tick();
      go = cfg_en && (!cfg_gate_en || mopen);
      hit = inc && (mcnt == mref);
      tr = mt[1] & ~mt[2]; tf = ~mt[1] & mt[2];
      gr = mg[1] & ~mg[2]; gf = ~mg[1] & mg[2];
      if ((cfg_cap_edge[0] && tr) || (cfg_cap_edge[1] && tf)) begin
        mcap = mcnt; mcapf = 1;
      end else if (cap_clr) mcapf = 0;
      if (cnt_wr) mcnt = cnt_wdata;
      else if (cfg_gate_en && cfg_gate_restart && gf) mcnt = 0;
      else if (inc) mcnt = (hit && cfg_ref_reset) ? 16'd0 : mcnt + 16'd1;
      mmp = hit;
      if (hit) mmf = 1; else if (match_clr) mmf = 0;
      if (pre_wr) mpq = 0;
      else if (go && st && cfg_src != 2'd3) mpq = (mpq == mpv) ? 8'd0 : mpq + 8'd1;
      if (pre_wr) mpv = pre_wdata;
      if (ref_wr) mref = ref_wdata;
      if (gf) mopen = 1; else if (gr) mopen = 0;
      mdiv = mdiv + 4'd1;
      mt = {mt[1:0], tin}; mg = {mg[1:0], gate_in};
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R2 R3 R5 R7 R8 R9 R11 count", count, mcnt);
    check("R6 capture", capture, mcap);
    check("R6 cap_flag", {15'd0, cap_flag}, {15'd0, mcapf});
    check("R4 match_pulse", {15'd0, match_pulse}, {15'd0, mmp});
    check("R4 match_flag", {15'd0, match_flag}, {15'd0, mmf});
    check("R10 carry_out", {15'd0, carry_out}, {15'd0, m_inc() && mcnt == 16'hFFFF});
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic strobes_off();
    pre_wr = 0; ref_wr = 0; cnt_wr = 0; match_clr = 0; cap_clr = 0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    tick(3); rst_n = 1; tick(1);
    check("R1 count", count, 0);
    check("R1 capture", capture, 0);
    check("R1 flags", {13'd0, match_pulse, match_flag, cap_flag}, 0);

    // R3: divide by 4 on system clock
    cnt_wr = 1; cnt_wdata = 0; pre_wr = 1; pre_wdata = 3; tick(1);
    strobes_off(); cfg_en = 1; tick(20);
    check("R3 prescale 3 over 20 clocks", count, 5);
    cfg_en = 0;

    // R10 / R11: load all ones then wrap
    cnt_wr = 1; cnt_wdata = 16'hFFFF; pre_wr = 1; pre_wdata = 0; tick(1);
    strobes_off();
    check("R11 load", count, 16'hFFFF);
    cfg_en = 1; #1;
    check("R10 carry at all ones", {15'd0, carry_out}, 1);
    tick(1);
    check("R10 wrap to zero", count, 0);
    cfg_en = 0; match_clr = 1; tick(1); strobes_off();

    // R4 / R5: reference 3, reset mode then free mode
    ref_wr = 1; ref_wdata = 3; cnt_wr = 1; cnt_wdata = 0; cfg_ref_reset = 1; tick(1);
    strobes_off(); cfg_en = 1; tick(4);
    check("R5 reset mode clears", count, 0);
    check("R4 match pulse", {15'd0, match_pulse}, 1);
    cfg_en = 0; cnt_wr = 1; cnt_wdata = 0; cfg_ref_reset = 0; tick(1);
    strobes_off(); cfg_en = 1; tick(4);
    check("R5 free mode passes reference", count, 4);
    cfg_en = 0;

    // R12: capture latency
    cnt_wr = 1; cnt_wdata = 7; cap_clr = 1; cfg_cap_edge = 2'b01; tin = 0; tick(1);
    strobes_off(); tick(3);
    tin = 1; tick(2);
    check("R12 no capture after two edges", {15'd0, cap_flag}, 0);
    tick(1);
    check("R12 capture after three edges", {15'd0, cap_flag}, 1);
    check("R12 captured value", capture, 7);

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      cfg_en = ($urandom % 8) != 0;
      cfg_src = 2'($urandom);
      cfg_ref_reset = 1'($urandom);
      cfg_gate_en = 1'($urandom);
      cfg_gate_restart = 1'($urandom);
      cfg_cap_edge = 2'($urandom);
      pre_wr = 1; pre_wdata = 8'($urandom % 4);
      ref_wr = 1; ref_wdata = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom % 40);
      tick(1); strobes_off();
      for (int c = 0; c < 300; c++) begin
        if ($urandom % 8 == 0) tin = ~tin;
        if ($urandom % 20 == 0) gate_in = ~gate_in;
        carry_in = 1'($urandom);
        if ($urandom % 64 == 0) begin
          cnt_wr = 1;
          cnt_wdata = 1'($urandom) ? 16'hFFF0 + 16'($urandom % 16) : 16'($urandom % 32);
        end
        match_clr = ($urandom % 16 == 0);
        cap_clr = ($urandom % 16 == 0);
        if ($urandom % 200 == 0) begin pre_wr = 1; pre_wdata = 8'($urandom % 4); end
        tick(1); strobes_off();
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule